// File: doc/BRIEF.md
# Display Controller Power-Up Sequencer

This block brings an external display controller out of reset and sets it up without any help from software. After its own synchronous reset it drives the controller's hardware reset line low for a set number of clocks, releases it, waits, and then plays a fixed program of 56 tagged bytes. Each byte is marked either as a command or as a parameter, and each one is handed to a downstream bus writer through a valid/ready handshake.

The program does the following in order. It issues three soft resets. It starts and then locks the PLL, and pauses for a programmable settle time after the lock. It sets the panel mode and size, the pixel interface width, the colour depth, the PLL multiplier, the pixel clock divider, and the horizontal and vertical timing. It then opens a full-panel drawing window, turns the display on, and issues a memory-write command. Panel width and height are parameters, and the size fields are sent as the size minus one. The other timing values are parameters with defaults.

When the last byte has been accepted the block raises `done` and stays idle until the next reset.

Top module: `panel_init_seq`

## Requirements
- R1: While `rst` is high, `panel_rst_n` is 0, `out_valid` is 0 and `done` is 0.
- R2: After `rst` falls, `panel_rst_n` stays 0 for exactly RST_LOW_CLKS cycles. It then goes to 1, and `out_valid` stays 0 for exactly RST_WAIT_CLKS more cycles before the first byte is offered.
- R3: `out_is_cmd` is 1 for a command byte and 0 for a parameter byte. The program advances by exactly one byte on each cycle where `out_valid` and `out_ready` are both 1. While `out_valid` is 1 and `out_ready` is 0, the offered byte and its tag are held unchanged.
- R4: The first seven bytes are: command 0x01 three times, then command 0xE0 with parameter 0x01, then command 0xE0 with parameter 0x03.
- R5: Once the 0x03 lock parameter is accepted, `out_valid` is 0 for exactly PLL_WAIT_CLKS cycles.
- R6: Command 0xB0 is followed by seven parameters, in this order:
  - MODE_A, then MODE_B;
  - (PANEL_W-1) high byte, then low byte;
  - (PANEL_H-1) high byte, then low byte;
  - 0x00.
- R7: The next bytes are, in order:
  - command 0xF0 with 0x00;
  - command 0x3A with 0x60;
  - command 0xE2 with 0x22, 0x03, 0x04;
  - command 0xE6 with the three bytes of PCLK_DIV, most significant byte first.
- R8: Command 0xB4 is followed by eight parameters, in this order:
  - H_TOTAL, high byte then low byte;
  - H_BACK, high byte then low byte;
  - H_PULSE-1 as one byte;
  - H_START, high byte then low byte;
  - H_SUBPIX.

  Command 0xB6 is followed by seven parameters with the same layout, taken from the V_ values, and no subpixel byte.
- R9: The program ends with the following, for a total of 56 bytes:
  - command 0x2A with 0x00, 0x00, then (PANEL_W-1) high byte, then low byte;
  - command 0x2B with the same layout for PANEL_H;
  - command 0x29;
  - command 0x2C.
- R10: `done` rises in the cycle after the final byte is accepted. From then on `out_valid` stays 0, `panel_rst_n` stays 1, and `out_ready` has no effect until reset.
- R11: Asserting `rst` in the middle of the program abandons it. The next run starts again from the reset pulse and the first byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| out_ready | input | 1 | Downstream writer accepts the offered byte |
| out_valid | output | 1 | A program byte is offered |
| out_is_cmd | output | 1 | 1: command byte, 0: parameter byte |
| out_byte | output | 8 | Offered byte value |
| panel_rst_n | output | 1 | Active-low hardware reset to the display controller |
| done | output | 1 | Program complete |

## Verification
The assertions check the following on every cycle:
- the offered byte is held steady while it is stalled;
- nothing is offered while the panel reset line is low;
- `done` is sticky, keeps `out_valid` low, and keeps the reset line high;
- exactly 56 handshakes have occurred when `done` rises.

Some behaviour can only be shown by the bench's scenarios:
- the exact byte values and their order;
- the lengths of the reset pulse, the post-reset wait and the PLL settle gap;
- the restart after a reset in mid-program.

The bench runs the whole program under three patterns of `out_ready` (always ready, pseudo-random, and one-in-three) with a non-default panel configuration.

// File: rtl/panel_init_pkg.sv
package panel_init_pkg;

    localparam logic [7:0] CMD_SOFT_RESET = 8'h01;
    localparam logic [7:0] CMD_PLL_CTRL   = 8'hE0;
    localparam logic [7:0] CMD_PANEL_MODE = 8'hB0;
    localparam logic [7:0] CMD_IFACE_FMT  = 8'hF0;
    localparam logic [7:0] CMD_PIXEL_FMT  = 8'h3A;
    localparam logic [7:0] CMD_PLL_MUL    = 8'hE2;
    localparam logic [7:0] CMD_PCLK_DIV   = 8'hE6;
    localparam logic [7:0] CMD_HTIMING    = 8'hB4;
    localparam logic [7:0] CMD_VTIMING    = 8'hB6;
    localparam logic [7:0] CMD_COL_WIN    = 8'h2A;
    localparam logic [7:0] CMD_ROW_WIN    = 8'h2B;
    localparam logic [7:0] CMD_DISP_ON    = 8'h29;
    localparam logic [7:0] CMD_MEM_WRITE  = 8'h2C;

    localparam int SEQ_LEN  = 56;
    localparam int IDX_W    = $clog2(SEQ_LEN);
    localparam int LOCK_IDX = 6;
    localparam int LAST_IDX = SEQ_LEN - 1;

    typedef struct packed {
        logic       is_cmd;
        logic [7:0] val;
    } seq_byte_t;

    typedef enum logic [2:0] {
        ST_RST_LOW,
        ST_RST_WAIT,
        ST_EMIT,
        ST_PLL_WAIT,
        ST_DONE
    } seq_state_t;

    function automatic seq_byte_t mk_cmd(input logic [7:0] v);
        seq_byte_t b;
        b.is_cmd = 1'b1;
        b.val    = v;
        return b;
    endfunction

    function automatic seq_byte_t mk_par(input logic [7:0] v);
        seq_byte_t b;
        b.is_cmd = 1'b0;
        b.val    = v;
        return b;
    endfunction

    function automatic logic [7:0] hi_byte(input logic [15:0] w);
        return w[15:8];
    endfunction

    function automatic logic [7:0] lo_byte(input logic [15:0] w);
        return w[7:0];
    endfunction

endpackage

// File: rtl/panel_init_rom.sv
module panel_init_rom
    import panel_init_pkg::*;
#(
    parameter int          PANEL_W  = 320,
    parameter int          PANEL_H  = 240,
    parameter logic [7:0]  MODE_A   = 8'h0C,
    parameter logic [7:0]  MODE_B   = 8'h00,
    parameter logic [23:0] PCLK_DIV = 24'h00EAEC,
    parameter logic [15:0] H_TOTAL  = 16'd440,
    parameter logic [15:0] H_BACK   = 16'd68,
    parameter int          H_PULSE  = 16,
    parameter logic [15:0] H_START  = 16'd0,
    parameter logic [7:0]  H_SUBPIX = 8'h00,
    parameter logic [15:0] V_TOTAL  = 16'd264,
    parameter logic [15:0] V_BACK   = 16'd18,
    parameter int          V_PULSE  = 8,
    parameter logic [15:0] V_START  = 16'd0
) (
    input  logic [IDX_W-1:0] idx,
    output seq_byte_t        entry
);

    localparam logic [15:0] W_M1  = 16'(PANEL_W - 1);
    localparam logic [15:0] H_M1  = 16'(PANEL_H - 1);
    localparam logic [7:0]  HPW_M1 = 8'(H_PULSE - 1);
    localparam logic [7:0]  VPW_M1 = 8'(V_PULSE - 1);

    always_comb begin
        case (int'(idx))
            0, 1, 2: entry = mk_cmd(CMD_SOFT_RESET);
            3:       entry = mk_cmd(CMD_PLL_CTRL);
            4:       entry = mk_par(8'h01);
            5:       entry = mk_cmd(CMD_PLL_CTRL);
            6:       entry = mk_par(8'h03);
            7:       entry = mk_cmd(CMD_PANEL_MODE);
            8:       entry = mk_par(MODE_A);
            9:       entry = mk_par(MODE_B);
            10:      entry = mk_par(hi_byte(W_M1));
            11:      entry = mk_par(lo_byte(W_M1));
            12:      entry = mk_par(hi_byte(H_M1));
            13:      entry = mk_par(lo_byte(H_M1));
            14:      entry = mk_par(8'h00);
            15:      entry = mk_cmd(CMD_IFACE_FMT);
            16:      entry = mk_par(8'h00);
            17:      entry = mk_cmd(CMD_PIXEL_FMT);
            18:      entry = mk_par(8'h60);
            19:      entry = mk_cmd(CMD_PLL_MUL);
            20:      entry = mk_par(8'h22);
            21:      entry = mk_par(8'h03);
            22:      entry = mk_par(8'h04);
            23:      entry = mk_cmd(CMD_PCLK_DIV);
            24:      entry = mk_par(PCLK_DIV[23:16]);
            25:      entry = mk_par(PCLK_DIV[15:8]);
            26:      entry = mk_par(PCLK_DIV[7:0]);
            27:      entry = mk_cmd(CMD_HTIMING);
            28:      entry = mk_par(hi_byte(H_TOTAL));
            29:      entry = mk_par(lo_byte(H_TOTAL));
            30:      entry = mk_par(hi_byte(H_BACK));
            31:      entry = mk_par(lo_byte(H_BACK));
            32:      entry = mk_par(HPW_M1);
            33:      entry = mk_par(hi_byte(H_START));
            34:      entry = mk_par(lo_byte(H_START));
            35:      entry = mk_par(H_SUBPIX);
            36:      entry = mk_cmd(CMD_VTIMING);
            37:      entry = mk_par(hi_byte(V_TOTAL));
            38:      entry = mk_par(lo_byte(V_TOTAL));
            39:      entry = mk_par(hi_byte(V_BACK));
            40:      entry = mk_par(lo_byte(V_BACK));
            41:      entry = mk_par(VPW_M1);
            42:      entry = mk_par(hi_byte(V_START));
            43:      entry = mk_par(lo_byte(V_START));
            44:      entry = mk_cmd(CMD_COL_WIN);
            45, 46:  entry = mk_par(8'h00);
            47:      entry = mk_par(hi_byte(W_M1));
            48:      entry = mk_par(lo_byte(W_M1));
            49:      entry = mk_cmd(CMD_ROW_WIN);
            50, 51:  entry = mk_par(8'h00);
            52:      entry = mk_par(hi_byte(H_M1));
            53:      entry = mk_par(lo_byte(H_M1));
            54:      entry = mk_cmd(CMD_DISP_ON);
            55:      entry = mk_cmd(CMD_MEM_WRITE);
            default: entry = mk_par(8'h00);
        endcase
    end

endmodule

// File: rtl/panel_init_timer.sv
module panel_init_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] len,
    output logic             hit
);

    logic [CNT_W-1:0] cnt;

    // Fires on the last cycle of a window of len cycles (len >= 1).
    assign hit = run && (cnt == len - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run || hit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/panel_init_ctrl.sv
module panel_init_ctrl
    import panel_init_pkg::*;
#(
    parameter int CNT_W         = 8,
    parameter int RST_LOW_CLKS  = 16,
    parameter int RST_WAIT_CLKS = 64,
    parameter int PLL_WAIT_CLKS = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             out_ready,
    input  logic             tmr_hit,
    output logic             tmr_run,
    output logic [CNT_W-1:0] tmr_len,
    output seq_state_t       state,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] LAST_I = IDX_W'(LAST_IDX);
    localparam logic [IDX_W-1:0] LOCK_I = IDX_W'(LOCK_IDX);

    seq_state_t       nxt_state;
    logic [IDX_W-1:0] nxt_idx;

    always_comb begin
        nxt_state = state;
        nxt_idx   = idx;
        tmr_run   = 1'b0;
        tmr_len   = CNT_W'(RST_LOW_CLKS);
        case (state)
            ST_RST_LOW: begin
                tmr_run = 1'b1;
                tmr_len = CNT_W'(RST_LOW_CLKS);
                if (tmr_hit) nxt_state = ST_RST_WAIT;
            end
            ST_RST_WAIT: begin
                tmr_run = 1'b1;
                tmr_len = CNT_W'(RST_WAIT_CLKS);
                if (tmr_hit) nxt_state = ST_EMIT;
            end
            ST_EMIT: begin
                if (out_ready) begin
                    if (idx == LAST_I) begin
                        nxt_state = ST_DONE;
                    end else begin
                        nxt_idx = idx + IDX_W'(1);
                        if (idx == LOCK_I) nxt_state = ST_PLL_WAIT;
                    end
                end
            end
            ST_PLL_WAIT: begin
                tmr_run = 1'b1;
                tmr_len = CNT_W'(PLL_WAIT_CLKS);
                if (tmr_hit) nxt_state = ST_EMIT;
            end
            ST_DONE: begin
                nxt_state = ST_DONE;
            end
            default: nxt_state = ST_RST_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RST_LOW;
            idx   <= '0;
        end else begin
            state <= nxt_state;
            idx   <= nxt_idx;
        end
    end

endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
    import panel_init_pkg::*;
#(
    parameter int          PANEL_W       = 320,
    parameter int          PANEL_H       = 240,
    parameter logic [7:0]  MODE_A        = 8'h0C,
    parameter logic [7:0]  MODE_B        = 8'h00,
    parameter logic [23:0] PCLK_DIV      = 24'h00EAEC,
    parameter logic [15:0] H_TOTAL       = 16'd440,
    parameter logic [15:0] H_BACK        = 16'd68,
    parameter int          H_PULSE       = 16,
    parameter logic [15:0] H_START       = 16'd0,
    parameter logic [7:0]  H_SUBPIX      = 8'h00,
    parameter logic [15:0] V_TOTAL       = 16'd264,
    parameter logic [15:0] V_BACK        = 16'd18,
    parameter int          V_PULSE       = 8,
    parameter logic [15:0] V_START       = 16'd0,
    parameter int          RST_LOW_CLKS  = 16,
    parameter int          RST_WAIT_CLKS = 64,
    parameter int          PLL_WAIT_CLKS = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       out_ready,
    output logic       out_valid,
    output logic       out_is_cmd,
    output logic [7:0] out_byte,
    output logic       panel_rst_n,
    output logic       done
);

    localparam int MAX_A   = (RST_LOW_CLKS > RST_WAIT_CLKS) ? RST_LOW_CLKS : RST_WAIT_CLKS;
    localparam int MAX_LEN = (MAX_A > PLL_WAIT_CLKS) ? MAX_A : PLL_WAIT_CLKS;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    seq_state_t       state;
    logic [IDX_W-1:0] idx;
    logic             tmr_run;
    logic             tmr_hit;
    logic [CNT_W-1:0] tmr_len;
    seq_byte_t        entry;

    panel_init_ctrl #(
        .CNT_W        (CNT_W),
        .RST_LOW_CLKS (RST_LOW_CLKS),
        .RST_WAIT_CLKS(RST_WAIT_CLKS),
        .PLL_WAIT_CLKS(PLL_WAIT_CLKS)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .out_ready(out_ready),
        .tmr_hit  (tmr_hit),
        .tmr_run  (tmr_run),
        .tmr_len  (tmr_len),
        .state    (state),
        .idx      (idx)
    );

    panel_init_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk(clk),
        .rst(rst),
        .run(tmr_run),
        .len(tmr_len),
        .hit(tmr_hit)
    );

    panel_init_rom #(
        .PANEL_W (PANEL_W),
        .PANEL_H (PANEL_H),
        .MODE_A  (MODE_A),
        .MODE_B  (MODE_B),
        .PCLK_DIV(PCLK_DIV),
        .H_TOTAL (H_TOTAL),
        .H_BACK  (H_BACK),
        .H_PULSE (H_PULSE),
        .H_START (H_START),
        .H_SUBPIX(H_SUBPIX),
        .V_TOTAL (V_TOTAL),
        .V_BACK  (V_BACK),
        .V_PULSE (V_PULSE),
        .V_START (V_START)
    ) u_rom (
        .idx  (idx),
        .entry(entry)
    );

    assign out_valid   = (state == ST_EMIT);
    assign out_is_cmd  = entry.is_cmd;
    assign out_byte    = entry.val;
    assign panel_rst_n = (state != ST_RST_LOW);
    assign done        = (state == ST_DONE);

endmodule

// File: rtl/panel_init_chk.sv
module panel_init_chk
    import panel_init_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       out_ready,
    input logic       out_valid,
    input logic       out_is_cmd,
    input logic [7:0] out_byte,
    input logic       panel_rst_n,
    input logic       done
);

    logic [6:0] hs_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_cnt <= '0;
        end else if (out_valid && out_ready) begin
            hs_cnt <= hs_cnt + 7'd1;
        end
    end

    a_r3_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_is_cmd)));

    a_r2_quiet_in_reset: assert property (@(posedge clk) disable iff (rst)
        !panel_rst_n |-> (!out_valid && !done));

    a_r10_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> (done && !out_valid));

    a_r10_line_high: assert property (@(posedge clk) disable iff (rst)
        done |-> panel_rst_n);

    a_r9_byte_total: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (hs_cnt == 7'(SEQ_LEN)));

endmodule

bind panel_init_seq panel_init_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_is_cmd (out_is_cmd),
    .out_byte   (out_byte),
    .panel_rst_n(panel_rst_n),
    .done       (done)
);

// File: tb/panel_init_seq_tb.sv
module panel_init_seq_tb;

    localparam int P_W   = 480;
    localparam int P_H   = 272;
    localparam int T_LOW = 3;
    localparam int T_RW  = 5;
    localparam int T_PLL = 7;
    localparam logic [23:0] P_PCLK = 24'h014547;
    localparam int HT = 525, HB = 43, HPW = 41, HS = 2, HSUB = 1;
    localparam int VT = 285, VB = 12, VPW = 10, VS = 3;
    localparam int N_BYTES = 56;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       out_ready = 1'b0;
    logic       out_valid, out_is_cmd, panel_rst_n, done;
    logic [7:0] out_byte;

    int n_checks = 0;
    int n_fail   = 0;

    int ev [64];
    bit ec [64];
    int en = 0;

    always #2 clk = ~clk;

    panel_init_seq #(
        .PANEL_W(P_W), .PANEL_H(P_H), .MODE_A(8'h08), .MODE_B(8'h20),
        .PCLK_DIV(P_PCLK),
        .H_TOTAL(16'(HT)), .H_BACK(16'(HB)), .H_PULSE(HPW), .H_START(16'(HS)), .H_SUBPIX(8'(HSUB)),
        .V_TOTAL(16'(VT)), .V_BACK(16'(VB)), .V_PULSE(VPW), .V_START(16'(VS)),
        .RST_LOW_CLKS(T_LOW), .RST_WAIT_CLKS(T_RW), .PLL_WAIT_CLKS(T_PLL)
    ) u_dut (
        .clk(clk), .rst(rst), .out_ready(out_ready), .out_valid(out_valid),
        .out_is_cmd(out_is_cmd), .out_byte(out_byte), .panel_rst_n(panel_rst_n), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic add(input bit c, input int v);
        ec[en] = c;
        ev[en] = v & 255;
        en++;
    endtask

    task automatic add16(input int v);
        add(0, v >> 8);
        add(0, v);
    endtask

    function automatic string req_of(input int i);
        if (i < 7)  return "R4";
        if (i < 15) return "R6";
        if (i < 27) return "R7";
        if (i < 44) return "R8";
        return "R9";
    endfunction

    task automatic build_expected();
        add(1, 'h01); add(1, 'h01); add(1, 'h01);
        add(1, 'hE0); add(0, 'h01); add(1, 'hE0); add(0, 'h03);
        add(1, 'hB0); add(0, 'h08); add(0, 'h20); add16(P_W - 1); add16(P_H - 1); add(0, 0);
        add(1, 'hF0); add(0, 0); add(1, 'h3A); add(0, 'h60);
        add(1, 'hE2); add(0, 'h22); add(0, 'h03); add(0, 'h04);
        add(1, 'hE6); add(0, int'(P_PCLK) >> 16); add(0, int'(P_PCLK) >> 8); add(0, int'(P_PCLK));
        add(1, 'hB4); add16(HT); add16(HB); add(0, HPW - 1); add16(HS); add(0, HSUB);
        add(1, 'hB6); add16(VT); add16(VB); add(0, VPW - 1); add16(VS);
        add(1, 'h2A); add16(0); add16(P_W - 1);
        add(1, 'h2B); add16(0); add16(P_H - 1);
        add(1, 'h29); add(1, 'h2C);
    endtask

    task automatic apply_reset();
        rst = 1'b1;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        check(!panel_rst_n && !out_valid && !done, "R1", "reset outputs",
              {panel_rst_n, out_valid, done}, 0);
        rst = 1'b0;
    endtask

    // mode 0: always ready, 1: pseudo-random ready, 2: ready one cycle in three
    task automatic run_seq(input int mode, input int abort_at);
        int low_cnt = 0, pre_cnt = 0, gap = 0, got = 0, cyc = 0;
        int stall_err = 0, last_acc = -10;
        bit prev_stall = 0;
        bit prev_c = 0;
        logic [7:0] prev_b = '0;
        logic [7:0] lf = 8'h5A;
        while (cyc < 5000) begin
            case (mode)
                0: out_ready = 1'b1;
                1: begin
                    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                    out_ready = lf[0];
                end
                default: out_ready = (cyc % 3 == 2);
            endcase
            if (prev_stall && !(out_valid && out_byte == prev_b && out_is_cmd == prev_c))
                stall_err++;
            if (done) begin
                check(got == N_BYTES && last_acc == cyc - 1 && !out_valid, "R10",
                      "done timing", cyc - last_acc, 1);
                break;
            end
            if (!panel_rst_n) low_cnt++;
            else if (!out_valid) begin
                if (got == 0) pre_cnt++;
                else if (got == 7) gap++;
            end
            if (out_valid && out_ready) begin
                check(out_is_cmd == ec[got] && int'(out_byte) == ev[got], req_of(got),
                      $sformatf("byte %0d (R3 tag)", got),
                      {out_is_cmd, out_byte}, (int'(ec[got]) << 8) | ev[got]);
                got++;
                last_acc = cyc;
            end
            prev_stall = out_valid && !out_ready;
            prev_b = out_byte;
            prev_c = out_is_cmd;
            if (abort_at != 0 && got == abort_at) break;
            cyc++;
            @(negedge clk);
        end
        if (abort_at == 0) begin
            check(low_cnt == T_LOW, "R2", "reset pulse length", low_cnt, T_LOW);
            check(pre_cnt == T_RW, "R2", "post-reset wait", pre_cnt, T_RW);
            check(gap == T_PLL, "R5", "pll settle gap", gap, T_PLL);
            check(stall_err == 0, "R3", "stall hold errors", stall_err, 0);
            check(got == N_BYTES, "R9", "byte total", got, N_BYTES);
        end
    endtask

    task automatic post_done();
        int bad = 0;
        out_ready = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (out_valid || !done || !panel_rst_n) bad++;
        end
        check(bad == 0, "R10", "idle after done", bad, 0);
    endtask

    initial begin
        build_expected();
        check(en == N_BYTES, "R9", "expected table size", en, N_BYTES);
        @(negedge clk);

        apply_reset();
        run_seq(0, 0);
        post_done();

        apply_reset();
        run_seq(1, 0);
        post_done();

        apply_reset();
        run_seq(2, 20);
        rst = 1'b1;
        @(negedge clk);
        check(!panel_rst_n && !out_valid && !done, "R11", "mid-program reset",
              {panel_rst_n, out_valid, done}, 0);
        apply_reset();
        run_seq(0, 0);
        post_done();

        apply_reset();
        run_seq(2, 0);
        post_done();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule